// File: doc/BRIEF.md
# Reflective TFT Line Strobe Generator

This block produces the per-line control waveforms that a high-reflectivity TFT panel needs next to its pixel bus. It runs from the pixel clock. Internal horizontal and vertical position counters step through a programmable raster. For each line the block drives a horizontal sync, a data-valid window over the active pixels, a one-pixel start pulse on the first active pixel, a gate-clock strobe, a power-save strobe and a line-alternating polarity-reversal signal.

The gate-clock, power-save and reversal edges are each placed by their own delay input. Every delay is counted in pixel clocks from the first pixel position after the last active pixel of the line. The frame geometry and the delays are static configuration inputs. They are expected to hold their values while the block runs out of reset. Four invert bits can flip the panel strobes when a panel needs the opposite polarity.

Top module: `hrtft_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge, the outputs take their idle values after that edge: hsync 0, de 0, spl 0, cls 0, ps 1 and rev 0, each before the invert bits are applied. The outputs are registered. In the first cycle after the first edge with `rst` low, they show position 0 of line 0.
- R2: A line lasts `cfg_htot_m1`+1 pixel clocks. `o_hsync` is high for the first `cfg_hsw` positions of every line.
- R3: `o_de` is high for exactly `cfg_fw`+1 consecutive positions, starting at position `cfg_bgxp`-1. This requires `cfg_bgxp` ≥ 1 and `cfg_bgxp`+`cfg_fw` ≤ `cfg_htot_m1`.
- R4: `o_spl` is high for exactly one pixel clock per line, at position `cfg_bgxp`-1, which is the first position where `o_de` is high.
- R5: The reference point is position `cfg_bgxp`+`cfg_fw`. `o_cls` is high from reference+`dly_cls_rise` up to the position before reference+`dly_cls_fall`, and is low elsewhere. Equal rise and fall delays give no pulse.
- R6: `o_ps` is low from reference+`dly_ps_fall` up to the position before reference+`dly_ps_rise`, and is high elsewhere. A zero CLS rise delay and a zero PS fall delay make the two edges coincide.
- R7: `o_rev` changes value exactly once per line, at position reference+`dly_rev`, so the level at the start of each line alternates from line to line.
- R8: A frame has `cfg_fh`+1 lines. At position 0 of line 0 of every frame, `o_rev` is 0, so its pattern repeats identically in every frame.
- R9: An edge position (reference + delay) that would pass `cfg_htot_m1` is clamped to `cfg_htot_m1`. The edge then still occurs on the last pixel clock of the line.
- R10: `cfg_inv` inverts the strobes at the outputs: bit 0 inverts spl, bit 1 cls, bit 2 ps and bit 3 rev. The invert bits also apply to the reset values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_htot_m1 | input | HW | Line length in pixel clocks, minus one |
| cfg_hsw | input | HW | Horizontal sync width in pixel clocks |
| cfg_bgxp | input | HW | Back-porch start; first active pixel at cfg_bgxp-1 |
| cfg_fw | input | HW | Active pixels per line, minus one |
| cfg_fh | input | VW | Lines per frame, minus one |
| dly_cls_rise | input | HW | CLS rising-edge delay from reference |
| dly_cls_fall | input | HW | CLS falling-edge delay from reference |
| dly_ps_fall | input | HW | PS falling-edge delay from reference |
| dly_ps_rise | input | HW | PS rising-edge delay from reference |
| dly_rev | input | HW | REV toggle delay from reference |
| cfg_inv | input | 4 | Output invert bits (spl, cls, ps, rev) |
| o_hsync | output | 1 | Horizontal sync |
| o_de | output | 1 | Active-pixel data window |
| o_spl | output | 1 | Start pulse on first active pixel |
| o_cls | output | 1 | Gate-clock strobe |
| o_ps | output | 1 | Power-save strobe |
| o_rev | output | 1 | Polarity reversal |

## Verification
Several properties are checked on every cycle. The start pulse never lasts more than one cycle and always lies inside the data window. The horizontal counter stays within the line. The raster wraps from the last line to line 0, position 0. Sync is asserted at the start of each line, and reversal is low at the start of each frame. Edge placement at exact positions needs the scenarios: the delay-defined edges, clamping of oversized delays, coincident CLS and PS edges, the invert bits and the full-size 320-pixel line are shown by comparing every output, on every cycle, against a position model in the bench.

// File: rtl/hrtft_pkg.sv
package hrtft_pkg;

    localparam int unsigned HW_DEF = 12;
    localparam int unsigned VW_DEF = 10;

    // Index of each programmable edge in the delay/position arrays
    typedef enum logic [2:0] {
        E_CLS_RISE = 3'd0,
        E_CLS_FALL = 3'd1,
        E_PS_FALL  = 3'd2,
        E_PS_RISE  = 3'd3,
        E_REV      = 3'd4
    } edge_e;
    localparam int unsigned N_EDGE = 5;

    // Bit positions inside the invert vector
    localparam int unsigned INV_SPL = 0;
    localparam int unsigned INV_CLS = 1;
    localparam int unsigned INV_PS  = 2;
    localparam int unsigned INV_REV = 3;
    localparam int unsigned INV_W   = 4;

    typedef struct packed {
        logic hsync;
        logic de;
        logic spl;
        logic cls;
        logic ps;
        logic rev;
    } strobe_t;

    localparam strobe_t STROBE_IDLE = '{hsync: 1'b0, de: 1'b0, spl: 1'b0,
                                        cls: 1'b0, ps: 1'b1, rev: 1'b0};

    function automatic strobe_t apply_inv(strobe_t s, logic [INV_W-1:0] inv);
        strobe_t r;
        r     = s;
        r.spl = s.spl ^ inv[INV_SPL];
        r.cls = s.cls ^ inv[INV_CLS];
        r.ps  = s.ps  ^ inv[INV_PS];
        r.rev = s.rev ^ inv[INV_REV];
        return r;
    endfunction

endpackage

// File: rtl/hrtft_raster.sv
module hrtft_raster
    import hrtft_pkg::*;
#(
    parameter int unsigned HW = HW_DEF,
    parameter int unsigned VW = VW_DEF
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [HW-1:0] htot_m1,
    input  logic [VW-1:0] fh,
    output logic [HW-1:0] h,
    output logic          line_end,
    output logic          frame_end,
    output logic          frame_start
);
    logic [VW-1:0] v;

    assign line_end    = (h == htot_m1);
    assign frame_end   = line_end && (v == fh);
    assign frame_start = (h == '0) && (v == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            h <= '0;
            v <= '0;
        end else if (line_end) begin
            h <= '0;
            v <= (v == fh) ? '0 : v + 1'b1;
        end else begin
            h <= h + 1'b1;
        end
    end

    p_h_bound_r2: assert property (@(posedge clk) disable iff (rst)
        h <= htot_m1);

    p_frame_wrap_r8: assert property (@(posedge clk) disable iff (rst)
        frame_end |=> (h == '0) && (v == '0));

endmodule

// File: rtl/hrtft_edges.sv
module hrtft_edges
    import hrtft_pkg::*;
#(
    parameter int unsigned HW = HW_DEF
) (
    input  logic [HW-1:0]             htot_m1,
    input  logic [HW-1:0]             bgxp,
    input  logic [HW-1:0]             fw,
    input  logic [N_EDGE-1:0][HW-1:0] dly,
    output logic [N_EDGE-1:0][HW-1:0] pos
);
    localparam int unsigned SW = HW + 2;

    logic [SW-1:0] ref_pt;
    assign ref_pt = SW'(bgxp) + SW'(fw);

    // One adder and clamp per programmable edge (R9)
    for (genvar g = 0; g < N_EDGE; g++) begin : g_edge
        logic [SW-1:0] sum;
        assign sum    = ref_pt + SW'(dly[g]);
        assign pos[g] = (sum > SW'(htot_m1)) ? htot_m1 : sum[HW-1:0];
    end

endmodule

// File: rtl/hrtft_outs.sv
module hrtft_outs
    import hrtft_pkg::*;
#(
    parameter int unsigned HW = HW_DEF
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [HW-1:0]             h,
    input  logic                      line_end,
    input  logic                      frame_end,
    input  logic                      frame_start,
    input  logic [HW-1:0]             hsw,
    input  logic [HW-1:0]             bgxp,
    input  logic [HW-1:0]             fw,
    input  logic [N_EDGE-1:0][HW-1:0] pos,
    input  logic [INV_W-1:0]          inv,
    output strobe_t                   st
);
    strobe_t     st_q, st_d;
    logic        par_q;
    logic [HW-1:0] first;
    logic [HW:0]   last;

    assign first = bgxp - 1'b1;
    assign last  = {1'b0, first} + {1'b0, fw};

    // Line parity: REV level at the start of the current line (R7, R8)
    always_ff @(posedge clk) begin
        if (rst || frame_end) par_q <= 1'b0;
        else if (line_end)    par_q <= ~par_q;
    end

    always_comb begin
        st_d       = STROBE_IDLE;
        st_d.hsync = (h < hsw);
        st_d.de    = (h >= first) && ({1'b0, h} <= last);
        st_d.spl   = (h == first);
        st_d.cls   = (h >= pos[int'(E_CLS_RISE)]) && (h < pos[int'(E_CLS_FALL)]);
        st_d.ps    = !((h >= pos[int'(E_PS_FALL)]) && (h < pos[int'(E_PS_RISE)]));
        st_d.rev   = par_q ^ (h >= pos[int'(E_REV)]);
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= STROBE_IDLE;
        else     st_q <= st_d;
    end

    assign st = apply_inv(st_q, inv);

    p_spl_single_r4: assert property (@(posedge clk) disable iff (rst)
        st_q.spl |=> !st_q.spl);

    p_spl_in_de_r4: assert property (@(posedge clk) disable iff (rst)
        st_q.spl |-> st_q.de);

    p_hsync_start_r2: assert property (@(posedge clk) disable iff (rst)
        (h == '0) && (hsw != '0) |=> st_q.hsync);

    p_rev_frame_r8: assert property (@(posedge clk) disable iff (rst)
        frame_start && (pos[int'(E_REV)] != '0) |=> !st_q.rev);

endmodule

// File: rtl/hrtft_ctrl.sv
module hrtft_ctrl
    import hrtft_pkg::*;
#(
    parameter int unsigned HW = HW_DEF,
    parameter int unsigned VW = VW_DEF
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [HW-1:0] cfg_htot_m1,
    input  logic [HW-1:0] cfg_hsw,
    input  logic [HW-1:0] cfg_bgxp,
    input  logic [HW-1:0] cfg_fw,
    input  logic [VW-1:0] cfg_fh,
    input  logic [HW-1:0] dly_cls_rise,
    input  logic [HW-1:0] dly_cls_fall,
    input  logic [HW-1:0] dly_ps_fall,
    input  logic [HW-1:0] dly_ps_rise,
    input  logic [HW-1:0] dly_rev,
    input  logic [3:0]    cfg_inv,
    output logic          o_hsync,
    output logic          o_de,
    output logic          o_spl,
    output logic          o_cls,
    output logic          o_ps,
    output logic          o_rev
);
    logic [HW-1:0]             h;
    logic                      line_end, frame_end, frame_start;
    logic [N_EDGE-1:0][HW-1:0] dly, pos;
    strobe_t                   st;

    assign dly[int'(E_CLS_RISE)] = dly_cls_rise;
    assign dly[int'(E_CLS_FALL)] = dly_cls_fall;
    assign dly[int'(E_PS_FALL)]  = dly_ps_fall;
    assign dly[int'(E_PS_RISE)]  = dly_ps_rise;
    assign dly[int'(E_REV)]      = dly_rev;

    hrtft_raster #(.HW(HW), .VW(VW)) u_raster (
        .clk(clk), .rst(rst), .htot_m1(cfg_htot_m1), .fh(cfg_fh),
        .h(h), .line_end(line_end), .frame_end(frame_end),
        .frame_start(frame_start)
    );

    hrtft_edges #(.HW(HW)) u_edges (
        .htot_m1(cfg_htot_m1), .bgxp(cfg_bgxp), .fw(cfg_fw),
        .dly(dly), .pos(pos)
    );

    hrtft_outs #(.HW(HW)) u_outs (
        .clk(clk), .rst(rst), .h(h), .line_end(line_end),
        .frame_end(frame_end), .frame_start(frame_start),
        .hsw(cfg_hsw), .bgxp(cfg_bgxp), .fw(cfg_fw), .pos(pos),
        .inv(cfg_inv), .st(st)
    );

    assign o_hsync = st.hsync;
    assign o_de    = st.de;
    assign o_spl   = st.spl;
    assign o_cls   = st.cls;
    assign o_ps    = st.ps;
    assign o_rev   = st.rev;

endmodule

// File: tb/sim_hrtft_ctrl.sv
`timescale 1ns/1ps
module sim_hrtft_ctrl;
    localparam int HW = 12;
    localparam int VW = 10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [HW-1:0] cfg_htot_m1, cfg_hsw, cfg_bgxp, cfg_fw;
    logic [VW-1:0] cfg_fh;
    logic [HW-1:0] dly_cls_rise, dly_cls_fall, dly_ps_fall, dly_ps_rise, dly_rev;
    logic [3:0]    cfg_inv;
    logic o_hsync, o_de, o_spl, o_cls, o_ps, o_rev;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    always #4 clk = ~clk;  // 125 MHz

    hrtft_ctrl #(.HW(HW), .VW(VW)) u0 (
        .clk(clk), .rst(rst), .cfg_htot_m1(cfg_htot_m1), .cfg_hsw(cfg_hsw),
        .cfg_bgxp(cfg_bgxp), .cfg_fw(cfg_fw), .cfg_fh(cfg_fh),
        .dly_cls_rise(dly_cls_rise), .dly_cls_fall(dly_cls_fall),
        .dly_ps_fall(dly_ps_fall), .dly_ps_rise(dly_ps_rise), .dly_rev(dly_rev),
        .cfg_inv(cfg_inv), .o_hsync(o_hsync), .o_de(o_de), .o_spl(o_spl),
        .o_cls(o_cls), .o_ps(o_ps), .o_rev(o_rev)
    );

    task automatic chk(input string req, input string sig, input logic act, input logic exp_v);
        n_chk++;
        if (act !== exp_v) begin
            n_bad++;
            $display("FAIL %s %s actual=%b expected=%b t=%0t", req, sig, act, exp_v, $time);
        end
    endtask

    task automatic set_cfg(input int htot_m1, input int hsw, input int bgxp, input int fw,
                           input int fh, input int cr, input int cf, input int pf,
                           input int pr, input int rv, input logic [3:0] inv);
        cfg_htot_m1 = HW'(htot_m1); cfg_hsw = HW'(hsw); cfg_bgxp = HW'(bgxp);
        cfg_fw = HW'(fw); cfg_fh = VW'(fh);
        dly_cls_rise = HW'(cr); dly_cls_fall = HW'(cf);
        dly_ps_fall = HW'(pf); dly_ps_rise = HW'(pr); dly_rev = HW'(rv);
        cfg_inv = inv;
    endtask

    function automatic int edge_at(input int d);
        int p;
        p = int'(cfg_bgxp) + int'(cfg_fw) + d;       // R5 reference point
        return (p > int'(cfg_htot_m1)) ? int'(cfg_htot_m1) : p;  // R9 clamp
    endfunction

    // Reset, release, then compare every output on every cycle against the position model
    task automatic run(input string tag, input int ncyc);
        int len, first, last, cr, cf, pf, pr, rv;
        @(negedge clk); rst = 1'b1;
        @(posedge clk); @(posedge clk); #1;
        // R1: idle values with invert bits applied (R10)
        chk({tag, " R1"}, "hsync", o_hsync, 1'b0);
        chk({tag, " R1"}, "de",    o_de,    1'b0);
        chk({tag, " R1"}, "spl",   o_spl,   cfg_inv[0]);
        chk({tag, " R1"}, "cls",   o_cls,   cfg_inv[1]);
        chk({tag, " R1"}, "ps",    o_ps,    ~cfg_inv[2]);
        chk({tag, " R1"}, "rev",   o_rev,   cfg_inv[3]);
        @(negedge clk); rst = 1'b0;
        len   = int'(cfg_htot_m1) + 1;
        first = int'(cfg_bgxp) - 1;
        last  = first + int'(cfg_fw);
        cr = edge_at(int'(dly_cls_rise)); cf = edge_at(int'(dly_cls_fall));
        pf = edge_at(int'(dly_ps_fall));  pr = edge_at(int'(dly_ps_rise));
        rv = edge_at(int'(dly_rev));
        for (int i = 0; i < ncyc; i++) begin
            int hm, vm;
            logic e_rev;
            @(posedge clk); #1;
            hm = i % len;
            vm = (i / len) % (int'(cfg_fh) + 1);
            e_rev = logic'(vm % 2) ^ (hm >= rv);     // R7 alternation, R8 frame restart
            chk({tag, " R2"}, "hsync", o_hsync, hm < int'(cfg_hsw));
            chk({tag, " R3"}, "de",    o_de,    (hm >= first) && (hm <= last));
            chk({tag, " R4"}, "spl",   o_spl,   (hm == first) ^ cfg_inv[0]);
            chk({tag, " R5"}, "cls",   o_cls,   ((hm >= cr) && (hm < cf)) ^ cfg_inv[1]);
            chk({tag, " R6"}, "ps",    o_ps,    !((hm >= pf) && (hm < pr)) ^ cfg_inv[2]);
            chk({tag, " R7"}, "rev",   o_rev,   e_rev ^ cfg_inv[3]);
        end
    endtask

    // R2-R8: small raster, three frames, distinct edge delays
    task automatic t_basic();
        set_cfg(19, 3, 4, 7, 2, 1, 4, 1, 3, 2, 4'h0);
        run("basic", 3 * 3 * 20);
    endtask

    // R9: oversized fall/rise/toggle delays land on the last position
    task automatic t_clamp();
        set_cfg(19, 2, 3, 9, 3, 2, 30, 5, 40, 50, 4'h0);
        run("clamp R9", 2 * 4 * 20);
    endtask

    // R5/R6: CLS rise and PS fall coincide at the reference point; empty PS window
    task automatic t_coincide();
        set_cfg(15, 1, 1, 5, 1, 0, 2, 0, 6, 0, 4'h0);
        run("coincide", 3 * 2 * 16);
        set_cfg(15, 1, 1, 5, 1, 1, 1, 3, 3, 1, 4'h0);
        run("empty-win", 2 * 2 * 16);
    endtask

    // R10: all invert bits, then a single bit
    task automatic t_invert();
        set_cfg(19, 3, 4, 7, 2, 1, 4, 1, 3, 2, 4'hF);
        run("invert R10", 2 * 3 * 20);
        set_cfg(19, 3, 4, 7, 2, 1, 4, 1, 3, 2, 4'h4);
        run("invert-ps R10", 3 * 20);
    endtask

    // R3/R4: 320 active pixels per line, 240-line frame, first lines checked
    task automatic t_wide();
        set_cfg(399, 16, 40, 319, 239, 3, 20, 2, 25, 10, 4'h0);
        run("wide", 4 * 400);
    endtask

    initial begin
        set_cfg(19, 3, 4, 7, 2, 1, 4, 1, 3, 2, 4'h0);
        t_basic();
        t_clamp();
        t_coincide();
        t_invert();
        t_wide();
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        #(200000 * 8);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

endmodule